// File: doc/BRIEF.md
# GPIO Data Register Bank

This block holds the data-side state of a 32-pin general-purpose I/O port behind a simple word-addressed register bus. Two 32-bit registers, pin direction and pin output level, each appear at four word addresses. One address is a plain read/write view. The other three are clear, set and toggle views, which change only the bits written as one. Software can therefore flip a single pin with one write and no read-modify-write. The direction register drives the per-pin output-enable vector and the output register drives the per-pin output-value vector. Bit index equals pin number throughout.

Raw pin levels enter through a multi-flop synchronizer and are then captured in an input register, which is read-only. A per-pin mode word selects how each pin is captured. A mode bit of one gives continuous capture: the input bit tracks the synchronized pin on every clock. A mode bit of zero gives on-demand capture: the input bit takes a new sample only when the input word is read. An on-demand pin therefore reports the level captured by the previous read of the input word.

Reads are registered. Read data appears the cycle after the read strobe and holds until the next read. A read and a write issued in the same cycle return the value from before the write.

Top module: `gpio_data_bank`

## Requirements
- R1: After reset, the direction, output, mode and input registers are all zero. As a result pin_oe, pin_out and bus_rdata are zero, and every pin starts as an input driving low.
- R2: A write to word 0 replaces the direction register and a write to word 4 replaces the output register. pin_oe and pin_out show the new value from the clock edge that takes the write.
- R3: A write to word 1 (direction) or word 5 (output) clears each register bit whose write-data bit is one and leaves the other bits unchanged.
- R4: A write to word 2 (direction) or word 6 (output) sets each register bit whose write-data bit is one and leaves the other bits unchanged. A write of all zeros changes nothing.
- R5: A write to word 3 (direction) or word 7 (output) inverts each register bit whose write-data bit is one and leaves the other bits unchanged.
- R6: A read of any word from 0 to 3 returns the direction register, and a read of any word from 4 to 7 returns the output register.
- R7: bus_rdata is loaded at the clock edge that samples bus_rd and holds its value while bus_rd is low. A read issued together with a write to the same register returns the value from before the write.
- R8: Pin levels pass through two flops before the input register captures them. For a pin whose mode bit is one, a level change present before edge k appears in a read of word 8 issued at edge k+3, but not in one issued at edge k+2.
- R9: For a pin whose mode bit is zero, the input bit changes only at an edge where word 8 is read. At that edge it loads the synchronized level, so each read of word 8 returns the sample taken by the previous read.
- R10: Word 9 is the read/write mode word, one bit per pin. A bit value of 1 selects continuous capture and 0 selects on-demand capture.
- R11: Writes to word 8 and to words 10 to 15 change no register. Reads of words 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels |
| pin_oe | output | 32 | Per-pin output enable (direction register) |
| pin_out | output | 32 | Per-pin output level (output register) |

## Verification
The in-RTL assertions check these properties on every cycle:
- clear, set and toggle writes touch no bit written as zero;
- registers hold when not written;
- read data stays stable between reads;
- on-demand input bits stay frozen between reads of the input word;
- unmapped reads return zero.

The bench's scenarios are needed to show:
- the exact values produced by chained alias writes;
- the two-flop capture latency, measured at an exact edge;
- the one-read-behind value of on-demand pins;
- read-before-write ordering on a combined access.

A behavioural model of all eight write views, plus a queue-based synchronizer, is compared against the outputs every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Low two address bits select how a write acts on the chosen register.
    typedef enum logic [1:0] {
        VIEW_PLAIN  = 2'd0,
        VIEW_CLEAR  = 2'd1,
        VIEW_SET    = 2'd2,
        VIEW_TOGGLE = 2'd3
    } view_e;

    typedef enum logic [2:0] {
        TGT_DIR,
        TGT_OUT,
        TGT_IN,
        TGT_MODE,
        TGT_NONE
    } target_e;

    localparam int WORD_OUT_BASE = 4;
    localparam int WORD_IN       = 8;
    localparam int WORD_MODE     = 9;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  view_e            view,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (view)
            VIEW_PLAIN:  nxt = wdata;
            VIEW_CLEAR:  nxt = q & ~wdata;
            VIEW_SET:    nxt = q | wdata;
            VIEW_TOGGLE: nxt = q ^ wdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= nxt;
    end

    AST_CLEAR_DROPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_CLEAR) |=> ((q & $past(wdata)) == '0)); // R3

    AST_SET_RAISES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_SET) |=> ((q & $past(wdata)) == $past(wdata))); // R4

    AST_ALIAS_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view != VIEW_PLAIN) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R2

endmodule

// File: rtl/gpio_in_sampler.sv
module gpio_in_sampler #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    input  logic [WIDTH-1:0] mode,
    input  logic             strobe,
    output logic [WIDTH-1:0] in_q
);

    localparam int CHAIN_W = SYNC_STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain_q;
    logic [WIDTH-1:0]   synced;
    logic [WIDTH-1:0]   in_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], pin_raw};
    end

    assign synced = chain_q[CHAIN_W-1 -: WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign in_next[b] = (mode[b] || strobe) ? synced[b] : in_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            in_q <= '0;
        else
            in_q <= in_next;
    end

    AST_ONDEMAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ((in_q & ~$past(mode)) == ($past(in_q) & ~$past(mode)))); // R9

endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out
);

    localparam logic [ADDR_W-1:0] A_OUT_BASE = ADDR_W'(WORD_OUT_BASE);
    localparam logic [ADDR_W-1:0] A_IN       = ADDR_W'(WORD_IN);
    localparam logic [ADDR_W-1:0] A_MODE     = ADDR_W'(WORD_MODE);
    localparam int                N_ALIAS    = 2;

    target_e          tgt;
    view_e            view;
    logic [WIDTH-1:0] alias_q [N_ALIAS];
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] in_q;
    logic [WIDTH-1:0] rd_mux;
    logic             in_strobe;

    // Address decode: words below the input word are the two aliased registers.
    always_comb begin
        view = view_e'(bus_addr[1:0]);
        if (bus_addr < A_OUT_BASE)
            tgt = TGT_DIR;
        else if (bus_addr < A_IN)
            tgt = TGT_OUT;
        else if (bus_addr == A_IN)
            tgt = TGT_IN;
        else if (bus_addr == A_MODE)
            tgt = TGT_MODE;
        else
            tgt = TGT_NONE;
    end

    for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
        localparam target_e MY_TGT = (g == 0) ? TGT_DIR : TGT_OUT;
        gpio_alias_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && (tgt == MY_TGT)),
            .view  (view),
            .wdata (bus_wdata),
            .q     (alias_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (bus_wr && tgt == TGT_MODE)
            mode_q <= bus_wdata;
    end

    assign in_strobe = bus_rd && (tgt == TGT_IN);

    gpio_in_sampler #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .mode    (mode_q),
        .strobe  (in_strobe),
        .in_q    (in_q)
    );

    always_comb begin
        unique case (tgt)
            TGT_DIR:  rd_mux = alias_q[0];
            TGT_OUT:  rd_mux = alias_q[1];
            TGT_IN:   rd_mux = in_q;
            TGT_MODE: rd_mux = mode_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign pin_oe  = alias_q[0];
    assign pin_out = alias_q[1];

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > A_MODE) |=> (bus_rdata == '0)); // R11

    AST_IN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= A_IN && bus_addr != A_MODE) |=> ($stable(pin_oe) && $stable(pin_out))); // R11

endmodule

// File: tb/sim_gpio_data_bank.sv
module sim_gpio_data_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    gpio_data_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Behavioural reference: eight write views, queue as synchronizer.
    logic [31:0] m_dir, m_out, m_mode, m_in, m_rdata, m_fresh, m_sync;
    logic [31:0] syncq [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_mode = 0; m_in = 0; m_rdata = 0;
            syncq = {32'h0, 32'h0};
        end else begin
            m_sync = syncq[0];
            if (bus_rd && bus_addr == 4'd8)
                m_fresh = m_sync;
            else
                m_fresh = (m_in & ~m_mode) | (m_sync & m_mode);
            if (bus_rd) begin
                if (bus_addr < 4)       m_rdata = m_dir;
                else if (bus_addr < 8)  m_rdata = m_out;
                else if (bus_addr == 8) m_rdata = m_in;
                else if (bus_addr == 9) m_rdata = m_mode;
                else                    m_rdata = 0;
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: m_dir = bus_wdata;
                    4'd1: m_dir = m_dir & ~bus_wdata;
                    4'd2: m_dir = m_dir | bus_wdata;
                    4'd3: m_dir = m_dir ^ bus_wdata;
                    4'd4: m_out = bus_wdata;
                    4'd5: m_out = m_out & ~bus_wdata;
                    4'd6: m_out = m_out | bus_wdata;
                    4'd7: m_out = m_out ^ bus_wdata;
                    4'd9: m_mode = bus_wdata;
                    default: ;
                endcase
            end
            m_in = m_fresh;
            void'(syncq.pop_front());
            syncq.push_back(pin_in);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (pin_oe !== m_dir || pin_out !== m_out || bus_rdata !== m_rdata) begin
                mismatched++;
                $display("FAIL R2 model: oe=%h/%h out=%h/%h rdata=%h/%h (actual/expected)",
                         pin_oe, m_dir, pin_out, m_out, bus_rdata, m_rdata);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(4'd0, 32'h0, "R1 dir");
        rd(4'd9, 32'h0, "R1 mode");

        wr(4'd0, 32'hA5A5_0F0F);
        check("R2 dir plain", pin_oe, 32'hA5A5_0F0F);
        wr(4'd4, 32'h1234_5678);
        check("R2 out plain", pin_out, 32'h1234_5678);

        wr(4'd1, 32'h0000_000F);
        check("R3 dir clear", pin_oe, 32'hA5A5_0F00);
        rd(4'd1, 32'hA5A5_0F00, "R6 read clear view");
        wr(4'd2, 32'h5A5A_0000);
        check("R4 dir set", pin_oe, 32'hFFFF_0F00);
        rd(4'd2, 32'hFFFF_0F00, "R6 read set view");
        wr(4'd3, 32'hFFFF_FFFF);
        check("R5 dir toggle", pin_oe, 32'h0000_F0FF);
        rd(4'd3, 32'h0000_F0FF, "R6 read toggle view");

        wr(4'd5, 32'hFFFF_0000);
        check("R3 out clear", pin_out, 32'h0000_5678);
        wr(4'd6, 32'h8000_0001);
        check("R4 out set", pin_out, 32'h8000_5679);
        wr(4'd7, 32'h0000_0009);
        check("R5 out toggle", pin_out, 32'h8000_5670);
        wr(4'd6, 32'h0);
        check("R4 zero set", pin_out, 32'h8000_5670);
        rd(4'd7, 32'h8000_5670, "R6 out via toggle view");

        repeat (3) @(negedge clk);
        check("R7 rdata hold", bus_rdata, 32'h8000_5670);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_00AA;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R7 read before write", bus_rdata, 32'h0000_F0FF);
        check("R7 write landed", pin_oe, 32'h0000_00AA);

        wr(4'd9, 32'h0000_00FF);
        rd(4'd9, 32'h0000_00FF, "R10 mode word");

        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        check("R11 oe unchanged", pin_oe, 32'h0000_00AA);
        check("R11 out unchanged", pin_out, 32'h8000_5670);
        rd(4'd13, 32'h0, "R11 unmapped read");
        rd(4'd9, 32'h0000_00FF, "R11 mode unchanged");

        pin_in = 32'h0000_0F3C;
        repeat (4) @(negedge clk);
        rd(4'd8, 32'h0000_003C, "R9 on-demand lags one read");
        rd(4'd8, 32'h0000_0F3C, "R9 on-demand captured");

        pin_in = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        rd(4'd8, 32'h0000_0F3C, "R8 not yet at edge k+2");
        rd(4'd8, 32'h0000_0001, "R8 visible at edge k+3");

        wr(4'd9, 32'h0);
        pin_in = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        rd(4'd8, 32'h0000_0001, "R9 all on-demand lag");
        rd(4'd8, 32'hFFFF_FFFF, "R9 all on-demand capture");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule